// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block sequences the word addresses for one DMA channel. Software-facing logic elsewhere supplies a start word address, a row length, a row stride, a row count and a direction tag, then pulses `start_i`. The generator then offers one word address at a time on a valid/ready handshake. The bus engine consumes each address and moves the data. The generator also raises single-cycle event pulses that an interrupt collector can gather.

With a non-zero row length the block walks a rectangle. Each row covers `row_len_i` consecutive words. Each row begins `stride_i` words after the start of the row before it. The row count field holds the number of rows minus one. The transfer ends after the last word of the last row.

A row length of zero selects the ring mode. The address climbs through a region of `stride_i * (row_cnt_i + 1)` words and then jumps back to the start address. An event fires at the end of each half of the region on every lap. The ring runs until `stop_i` aborts it. `stop_i` aborts either mode at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `busy_o`, `addr_valid_o`, `addr_last_row_o`, `dir_o` and all three event outputs are low.
- R2: When the block is idle and `stop_i` is low, a high `start_i` at a rising edge is accepted. From the next cycle `busy_o` and `addr_valid_o` are high, and `addr_o` equals the start address.
- R3: In rectangle mode (row length L > 0), the word offered for row r, column c is start + r*stride + c. `addr_last_row_o` is high exactly while c = L-1. The address advances only on a beat, where a beat is `addr_valid_o & addr_ready_i & ~stop_i` at a rising edge.
- R4: The row count field N gives N+1 rows, so N = 0 means one row. `row_done_o` is high for exactly the one cycle that follows the beat carrying the last word of each row.
- R5: `xfer_done_o` is high for exactly the one cycle that follows the beat carrying the last word of the last row. In that same cycle `busy_o` and `addr_valid_o` are already low.
- R6: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_o`, `addr_last_row_o` and `addr_valid_o` hold their values.
- R7: In ring mode (L = 0), the k-th beat (counting from 0) carries start + (k mod S), with S = stride*(N+1). If that product is zero, S is taken as 1. `addr_last_row_o` stays low, and the ring never ends by itself.
- R8: In ring mode, let H = floor(S/2). `half_done_o` is high for one cycle after each beat whose offset is S-1, and after each beat whose offset is H-1 when H > 0. It never coincides with `row_done_o` or `xfer_done_o`.
- R9: A high `stop_i` at a rising edge makes the block idle from the next cycle with no event pulse. A handshake in that same cycle does not count as a beat.
- R10: A `start_i` that arrives while busy, or together with `stop_i`, is ignored. The running sequence and `dir_o` are unchanged.
- R11: A stride smaller than the row length, including zero, is legal, and rows then overlap following the formula of R3.
- R12: `dir_o` takes the value of `dir_i` at the accepted start and keeps it until the next accepted start. Later changes on `dir_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Synchronous abort |
| base_i | input | AW | Start word address (byte address shifted right by two) |
| row_len_i | input | LW | Words per row; zero selects ring mode |
| stride_i | input | SW | Words between successive row starts |
| row_cnt_i | input | RW | Number of rows minus one |
| dir_i | input | 1 | Direction tag captured at start |
| busy_o | output | 1 | A sequence is running |
| dir_o | output | 1 | Captured direction tag |
| addr_valid_o | output | 1 | An address is offered |
| addr_ready_i | input | 1 | Consumer accepts the offered address |
| addr_o | output | AW | Offered word address |
| addr_last_row_o | output | 1 | Offered word ends its row |
| row_done_o | output | 1 | One-cycle pulse after a row completes |
| xfer_done_o | output | 1 | One-cycle pulse after the rectangle completes |
| half_done_o | output | 1 | One-cycle pulse after a ring half completes |

## Verification
The bench uses a rectangle whose rows overlap (stride below the row length) and a zero stride in ring mode. Both catch a generator that derives rows or ring size from the wrong term. A design using `row_cnt_i` as a plain count would emit one row too many or too few. A ring of odd size checks that the mid event falls at floor(S/2)-1 and not at a rounded-up point. Stalls with ready low, a stop that lands on an accepted handshake, and a second start during a run each expose a generator that advances, raises an event or reloads its setup when it must not.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_RECT = 2'd1,
    WALK_RING = 2'd2
  } walk_state_e;
endpackage

// File: rtl/dma2d_rect_walker.sv
module dma2d_rect_walker #(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int SW = 16,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  input  logic [SW-1:0] stride_i,
  input  logic [RW-1:0] rows_i,
  output logic [AW-1:0] addr_o,
  output logic          row_end_o,
  output logic          last_o
);
  logic [AW-1:0] row_base_q, row_base_d;
  logic [LW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic [LW-1:0] len_q;
  logic [SW-1:0] stride_q;
  logic [RW-1:0] rows_q;
  logic          cfg_en, walk_en;

  assign row_end_o = (col_q == (len_q - LW'(1)));
  assign last_o    = row_end_o && (row_q == rows_q);
  assign addr_o    = row_base_q + AW'(col_q);

  assign cfg_en  = load_i;
  assign walk_en = load_i | step_i;

  always_comb begin
    row_base_d = row_base_q;
    col_d      = col_q;
    row_d      = row_q;
    if (load_i) begin
      row_base_d = base_i;
      col_d      = '0;
      row_d      = '0;
    end else if (step_i) begin
      if (row_end_o) begin
        col_d      = '0;
        row_d      = row_q + RW'(1);
        row_base_d = row_base_q + AW'(stride_q);
      end else begin
        col_d = col_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      stride_q <= '0;
      rows_q   <= '0;
    end else if (cfg_en) begin
      len_q    <= len_i;
      stride_q <= stride_i;
      rows_q   <= rows_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_base_q <= '0;
      col_q      <= '0;
      row_q      <= '0;
    end else if (walk_en) begin
      row_base_q <= row_base_d;
      col_q      <= col_d;
      row_q      <= row_d;
    end
  end

  // R3: the column wraps to zero after the last word of a row
  assert_col_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && row_end_o) |=> (col_q == '0));

  // R4: the row index advances by exactly one at a row end
  assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && row_end_o) |=> (row_q == $past(row_q) + RW'(1)));
endmodule

// File: rtl/dma2d_ring_walker.sv
module dma2d_ring_walker #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] stride_i,
  input  logic [RW-1:0] rows_i,
  output logic [AW-1:0] addr_o,
  output logic          half_evt_o
);
  localparam int ZW = SW + RW;

  logic [AW-1:0] base_q;
  logic [ZW-1:0] off_q, off_d;
  logic [ZW-1:0] size_q, half_q;
  logic [ZW-1:0] size_raw, size_d;
  logic          wrap, mid;
  logic          cfg_en, walk_en;

  assign size_raw = ZW'(stride_i) * (ZW'(rows_i) + ZW'(1));
  assign size_d   = (size_raw == '0) ? ZW'(1) : size_raw;

  assign wrap       = (off_q == (size_q - ZW'(1)));
  assign mid        = (half_q != '0) && (off_q == (half_q - ZW'(1)));
  assign half_evt_o = wrap | mid;
  assign addr_o     = base_q + AW'(off_q);

  assign cfg_en  = load_i;
  assign walk_en = load_i | step_i;

  always_comb begin
    off_d = off_q;
    if (load_i)      off_d = '0;
    else if (step_i) off_d = wrap ? '0 : off_q + ZW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= ZW'(1);
      half_q <= '0;
    end else if (cfg_en) begin
      base_q <= base_i;
      size_q <= size_d;
      half_q <= size_d >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       off_q <= '0;
    else if (walk_en) off_q <= off_d;
  end

  // R7: the ring offset never leaves the region
  assert_off_in_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (off_q < size_q));

  // R7: a beat at the final offset returns to the start of the ring
  assert_ring_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && step_i && !load_i && wrap) |=> (off_q == '0));
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int SW = 16,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] row_len_i,
  input  logic [SW-1:0] stride_i,
  input  logic [RW-1:0] row_cnt_i,
  input  logic          dir_i,
  output logic          busy_o,
  output logic          dir_o,
  output logic          addr_valid_o,
  input  logic          addr_ready_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_last_row_o,
  output logic          row_done_o,
  output logic          xfer_done_o,
  output logic          half_done_o
);
  import dma2d_pkg::*;

  walk_state_e   state_q, state_d;
  logic          dir_q;
  logic          row_ev_q, xfer_ev_q, half_ev_q;
  logic          row_ev_d, xfer_ev_d, half_ev_d;
  logic          accept, beat, ring_sel;
  logic          in_rect, in_ring;
  logic [AW-1:0] rect_addr, ring_addr;
  logic          rect_row_end, rect_last, ring_half;

  assign in_rect  = (state_q == WALK_RECT);
  assign in_ring  = (state_q == WALK_RING);
  assign busy_o   = (state_q != WALK_IDLE);
  assign ring_sel = (row_len_i == '0);
  assign accept   = (state_q == WALK_IDLE) && start_i && !stop_i;
  assign beat     = busy_o && addr_ready_i && !stop_i;

  dma2d_rect_walker #(.AW(AW), .LW(LW), .SW(SW), .RW(RW)) rect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept && !ring_sel),
    .step_i    (beat && in_rect),
    .base_i    (base_i),
    .len_i     (row_len_i),
    .stride_i  (stride_i),
    .rows_i    (row_cnt_i),
    .addr_o    (rect_addr),
    .row_end_o (rect_row_end),
    .last_o    (rect_last)
  );

  dma2d_ring_walker #(.AW(AW), .SW(SW), .RW(RW)) ring_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (in_ring),
    .load_i     (accept && ring_sel),
    .step_i     (beat && in_ring),
    .base_i     (base_i),
    .stride_i   (stride_i),
    .rows_i     (row_cnt_i),
    .addr_o     (ring_addr),
    .half_evt_o (ring_half)
  );

  always_comb begin
    state_d = state_q;
    if (stop_i) begin
      state_d = WALK_IDLE;
    end else begin
      unique case (state_q)
        WALK_IDLE: if (accept) state_d = ring_sel ? WALK_RING : WALK_RECT;
        WALK_RECT: if (beat && rect_last) state_d = WALK_IDLE;
        WALK_RING: state_d = WALK_RING;
        default:   state_d = WALK_IDLE;
      endcase
    end
  end

  assign row_ev_d  = beat && in_rect && rect_row_end;
  assign xfer_ev_d = beat && in_rect && rect_last;
  assign half_ev_d = beat && in_ring && ring_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WALK_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= 1'b0;
    else if (accept) dir_q <= dir_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_ev_q  <= 1'b0;
      xfer_ev_q <= 1'b0;
      half_ev_q <= 1'b0;
    end else begin
      row_ev_q  <= row_ev_d;
      xfer_ev_q <= xfer_ev_d;
      half_ev_q <= half_ev_d;
    end
  end

  assign dir_o           = dir_q;
  assign addr_valid_o    = busy_o;
  assign addr_o          = in_ring ? ring_addr : rect_addr;
  assign addr_last_row_o = in_rect && rect_row_end;
  assign row_done_o      = row_ev_q;
  assign xfer_done_o     = xfer_ev_q;
  assign half_done_o     = half_ev_q;

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i && !stop_i) |=>
      (addr_valid_o && $stable(addr_o) && $stable(addr_last_row_o)));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> (!busy_o && !addr_valid_o && row_done_o));

  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!busy_o && !row_done_o && !xfer_done_o && !half_done_o));

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(dir_o));

  assert_half_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    half_done_o |-> (!row_done_o && !xfer_done_o));
endmodule

// File: tb/dma2d_addr_gen_tb_top.sv
module dma2d_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int LW = 12;
  localparam int SW = 16;
  localparam int RW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st = 1'b0, sp = 1'b0, dir = 1'b0, rdy = 1'b1;
  logic [AW-1:0] base = '0;
  logic [LW-1:0] len = '0;
  logic [SW-1:0] stride = '0;
  logic [RW-1:0] rows = '0;
  logic          busy, dir_out, vld, last_row, ev_row, ev_x, ev_h;
  logic [AW-1:0] addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit    cmp_en = 1'b0;
  string addr_tag = "R3";

  always #2 clk = ~clk;

  dma2d_addr_gen #(.AW(AW), .LW(LW), .SW(SW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(st), .stop_i(sp), .base_i(base),
    .row_len_i(len), .stride_i(stride), .row_cnt_i(rows), .dir_i(dir),
    .busy_o(busy), .dir_o(dir_out), .addr_valid_o(vld), .addr_ready_i(rdy),
    .addr_o(addr), .addr_last_row_o(last_row), .row_done_o(ev_row),
    .xfer_done_o(ev_x), .half_done_o(ev_h)
  );

  // reference model state
  bit          m_busy, m_ring, m_dir, e_row, e_x, e_h;
  int          m_r, m_c, m_len, m_stride, m_rows, m_size, m_nb;
  logic [31:0] m_base;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ring = 0; m_dir = 0; e_row = 0; e_x = 0; e_h = 0;
      m_r = 0; m_c = 0; m_len = 0; m_stride = 0; m_rows = 0; m_size = 1; m_nb = 0;
      m_base = '0;
    end else begin
      e_row = 0; e_x = 0; e_h = 0;
      if (m_busy) begin
        if (sp) m_busy = 0;
        else if (rdy) begin
          if (m_ring) begin
            int k;
            k = m_nb % m_size;
            if (k == m_size - 1 || (m_size / 2 != 0 && k == m_size / 2 - 1)) e_h = 1;
            m_nb++;
          end else if (m_c == m_len - 1) begin
            e_row = 1;
            if (m_r == m_rows) begin e_x = 1; m_busy = 0; end
            else begin m_r++; m_c = 0; end
          end else m_c++;
        end
      end else if (st && !sp) begin
        m_busy = 1; m_dir = dir; m_base = base;
        m_len = int'(len); m_stride = int'(stride); m_rows = int'(rows);
        m_ring = (len == '0);
        m_size = m_stride * (m_rows + 1);
        if (m_size == 0) m_size = 1;
        m_r = 0; m_c = 0; m_nb = 0;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rdy_mode == 1) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy  <= lfsr[0] | lfsr[3];
    end else rdy <= (rdy_mode == 0);
    if (cmp_en) begin
      logic [31:0] ea;
      chk("R2", "busy", 32'(busy), 32'(m_busy));
      chk("R2", "valid", 32'(vld), 32'(m_busy));
      chk("R12", "dir", 32'(dir_out), 32'(m_dir));
      chk("R4", "row_done", 32'(ev_row), 32'(e_row));
      chk("R5", "xfer_done", 32'(ev_x), 32'(e_x));
      chk("R8", "half_done", 32'(ev_h), 32'(e_h));
      chk("R3", "last_in_row", 32'(last_row), 32'(m_busy && !m_ring && m_c == m_len - 1));
      if (m_busy) begin
        if (m_ring) ea = m_base + 32'(m_nb % m_size);
        else        ea = m_base + 32'(m_r * m_stride + m_c);
        chk(addr_tag, "addr", addr, ea);
      end
    end
  end

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic go(input logic [31:0] b, input int l, input int s, input int r, input bit d);
    @(negedge clk);
    base = b; len = LW'(l); stride = SW'(s); rows = RW'(r); dir = d; st = 1'b1;
    @(negedge clk);
    st = 1'b0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "valid", 32'(vld), 0);
    chk("R1", "events", 32'({ev_row, ev_x, ev_h, last_row, dir_out}), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R2/R3/R4/R5 plain rectangle
    go(32'h100, 4, 8, 2, 1'b0);
    chk("R2", "first addr", addr, 32'h100);
    wait_idle();
    // R4 single row of one word
    go(32'h20, 1, 3, 0, 1'b1);
    wait_idle();
    chk("R5", "idle after one row", 32'(busy), 0);
    // R3 with random ready
    rdy_mode = 1;
    go(32'h3000, 3, 5, 3, 1'b0);
    wait_idle();
    // R11 overlapping rows and zero stride
    addr_tag = "R11";
    go(32'h500, 5, 2, 2, 1'b1);
    wait_idle();
    go(32'h600, 2, 0, 3, 1'b0);
    wait_idle();
    rdy_mode = 0;

    // R6 stall
    addr_tag = "R3";
    go(32'h800, 6, 6, 1, 1'b0);
    repeat (2) @(negedge clk);
    rdy_mode = 2;
    @(negedge clk);
    begin
      logic [31:0] held;
      @(negedge clk);
      held = addr;
      repeat (4) @(negedge clk);
      chk("R6", "held addr", addr, held);
      chk("R6", "held valid", 32'(vld), 1);
    end
    rdy_mode = 0;
    wait_idle();

    // R10/R12 start and dir changes while busy are ignored
    go(32'h900, 6, 7, 1, 1'b1);
    repeat (2) @(negedge clk);
    base = 32'h1234; len = '0; dir = 1'b0; st = 1'b1;
    @(negedge clk);
    st = 1'b0;
    chk("R10", "dir kept", 32'(dir_out), 1);
    chk("R12", "busy kept", 32'(busy), 1);
    wait_idle();
    chk("R12", "dir after run", 32'(dir_out), 1);

    // R7/R8 ring, even size 6
    addr_tag = "R7";
    rdy_mode = 1;
    go(32'h400, 0, 3, 1, 1'b0);
    repeat (40) @(negedge clk);
    chk("R7", "ring still busy", 32'(busy), 1);
    sp = 1'b1;
    @(negedge clk);
    sp = 1'b0;
    chk("R9", "idle after stop", 32'(busy), 0);
    // odd size 5
    go(32'h700, 0, 5, 0, 1'b1);
    repeat (30) @(negedge clk);
    sp = 1'b1; @(negedge clk); sp = 1'b0;
    // zero stride -> one-word ring
    rdy_mode = 0;
    go(32'hA00, 0, 0, 4, 1'b0);
    repeat (6) @(negedge clk);
    chk("R7", "one-word ring addr", addr, 32'hA00);
    // R9 stop together with start while ring runs: stop wins, start ignored
    sp = 1'b1; st = 1'b1; @(negedge clk); sp = 1'b0; st = 1'b0;
    chk("R9", "stop beats start", 32'(busy), 0);
    chk("R9", "no event", 32'({ev_row, ev_x, ev_h}), 0);

    // R9 stop in rectangle mode on an accepted handshake
    addr_tag = "R3";
    go(32'hC00, 8, 8, 3, 1'b0);
    repeat (5) @(negedge clk);
    sp = 1'b1; @(negedge clk); sp = 1'b0;
    chk("R9", "rect stopped", 32'(busy), 0);
    chk("R9", "no xfer_done", 32'(ev_x), 0);
    repeat (3) @(negedge clk);
    // R10 start together with stop while idle is ignored
    sp = 1'b1; st = 1'b1; @(negedge clk); sp = 1'b0; st = 1'b0;
    chk("R10", "start with stop ignored", 32'(busy), 0);
    // restart works after stop
    go(32'hD00, 2, 4, 1, 1'b1);
    wait_idle();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule